// File: doc/BRIEF.md
# Programmable serial frame master (SPI format)

This block is the shifting engine of a synchronous serial master port. It takes one parallel word at a time over a valid/ready handshake and sends it as one frame on a four-wire SPI-style bus. Each frame is 4 to 16 bits long, most significant bit first. While it sends, it samples the serial input line and returns the received word with a one-cycle valid strobe. Clock idle level and sampling phase are programmable. The bit rate comes from an even prescaler chained with a rate divider. A loopback switch routes the outgoing data line back to the capture logic, so the path can be tested without a far-end device.

Control is a small three-state machine. In IDLE, select is high and the clock rests at its idle level. Accepting a word (transition IDLE->SHIFT, "start") drops select. SHIFT issues the 2N clock transitions of an N-bit frame. After the last transition it moves to TRAIL ("last edge"). TRAIL waits one half-period. When the half-period ends and a new word is offered, the machine takes it and returns to SHIFT with select still low ("chain"). Otherwise it goes back to IDLE and releases select ("release"). Dropping the enable takes any state straight to IDLE ("abort").

Top module: `spi_frame_master`

## Requirements
- R1: The size field holds frame length minus one. Values 3 to 15 give frames of 4 to 16 bits, and each frame has exactly 2N transitions of the serial clock.
- R2: Data leaves the block most significant bit first. Only the low N bits of the transmit word are sent.
- R3: After the last clock transition of a frame, rx_valid is high for exactly one cycle. In that cycle rx_data holds the N captured bits, first-captured bit as the MSB, zero-extended to 16 bits.
- R4: While select is high, the serial clock equals the polarity input (0 = rests low, 1 = rests high).
- R5: Transitions are numbered 0 to 2N-1. With phase 0 the input is captured on the even-numbered transitions, and with phase 1 on the odd-numbered ones. The output bit changes only on transitions of the other parity; bit N-1 is driven from the start of the frame.
- R6: With P = prescale with bit 0 cleared (P = 2 when that gives 0), each half-period of the serial clock lasts (P/2)*(rate+1) clock cycles.
- R7: Select falls one half-period before the first clock transition. When no further word is taken, select rises one half-period after the last transition.
- R8: A word offered when the trailing half-period ends starts the next frame with select kept low. Its first transition comes two half-periods after the previous frame's last one.
- R9: With loopback set, the capture logic samples the block's own data output, and the serial input pin is ignored.
- R10: While enable is low, tx_ready is low, select is high and the clock stays at its idle level. Dropping enable during a frame ends it within one cycle.
- R11: busy is high whenever select is low or tx_valid is high.
- R12: tx_ready is high only when enabled and in IDLE, or at the final cycle of TRAIL. A word is taken in a cycle where tx_valid and tx_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| loopback | input | 1 | Route data output to capture logic |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Capture phase select |
| dsize | input | 4 | Frame length minus one |
| prescale | input | 8 | Even prescale divisor |
| rate | input | 8 | Rate divider, divides by rate+1 |
| tx_data | input | 16 | Word to send |
| tx_valid | input | 1 | tx_data offered |
| tx_ready | output | 1 | Block takes the word this cycle |
| miso | input | 1 | Serial data input |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data output |
| cs_n | output | 1 | Active-low select |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | rx_data valid strobe |
| busy | output | 1 | Frame in progress or word pending |

## Verification
The bench acts as a far-end device. It drives an independent random word on the input line and collects the output line on the capture-parity transitions, using all four polarity/phase combinations and random frame lengths. A reversed bit order, a wrong sampling parity or a bad length mask therefore shows up in either the sent or the received word. Spacing between transitions is measured for several prescale/rate pairs, including the odd and zero prescale corners, which separates half-period errors from lead and trail errors. Chained bursts, loopback with an inverted input pin, and enable drops before and during a frame separate the chain, loopback and abort paths from the plain single-frame path.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2
    } fm_state_e;
endpackage

// File: rtl/spi_fm_tick.sv
// Half-period strobe: (P/2)*(rate+1) cycles, P = even prescale (0 -> 2).
module spi_fm_tick #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8,
    localparam int CNT_W = PRE_W + RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pre_half;
    logic [CNT_W-1:0] rate_p1;
    logic [CNT_W-1:0] half_len;

    always_comb begin
        if (prescale[PRE_W-1:1] == '0)
            pre_half = CNT_W'(1);
        else
            pre_half = CNT_W'(prescale[PRE_W-1:1]);
        rate_p1  = CNT_W'(rate) + CNT_W'(1);
        half_len = pre_half * rate_p1;
        tick     = run && (cnt_q == half_len - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/spi_fm_shifter.sv
// Transmit and receive shift registers, MSB first.
module spi_fm_shifter #(
    parameter int DW = 16,
    localparam int LW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] tx_word,
    input  logic [LW-1:0] len_m1,
    input  logic          shift_en,
    input  logic          cap_en,
    input  logic          sin,
    output logic          sout,
    output logic [DW-1:0] rx_word
);
    logic [DW-1:0] tx_sr;
    logic [DW-1:0] rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= tx_word;
            rx_sr <= '0;
        end else begin
            if (shift_en) tx_sr <= {tx_sr[DW-2:0], 1'b0};
            if (cap_en)   rx_sr <= {rx_sr[DW-2:0], sin};
        end
    end

    assign sout    = tx_sr[len_m1];
    assign rx_word = rx_sr;
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int DW     = 16,
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8,
    localparam int LW    = $clog2(DW),
    localparam int EW    = LW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              loopback,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [LW-1:0]     dsize,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [RATE_W-1:0] rate,
    input  logic [DW-1:0]     tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic [DW-1:0]     rx_data,
    output logic              rx_valid,
    output logic              busy
);
    fm_state_e     state_q, state_d;
    logic [EW-1:0] edge_q;
    logic          ph_q;
    logic          rxv_q;
    logic          tick;
    logic          run;
    logic          take;
    logic          edge_last;
    logic          step;
    logic          cap_en;
    logic          shift_en;
    logic          sout;
    logic          sin;

    assign run       = (state_q != ST_IDLE);
    assign edge_last = (edge_q == {dsize, 1'b1});
    assign step      = enable && (state_q == ST_SHIFT) && tick;
    assign cap_en    = step && (edge_q[0] == cpha);
    assign shift_en  = step && (edge_q[0] != cpha) && (edge_q != '0) && !edge_last;
    assign take      = tx_valid && tx_ready;
    assign sin       = loopback ? sout : miso;

    spi_fm_tick #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .prescale (prescale),
        .rate     (rate),
        .tick     (tick)
    );

    spi_fm_shifter #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .tx_word  (tx_data),
        .len_m1   (dsize),
        .shift_en (shift_en),
        .cap_en   (cap_en),
        .sin      (sin),
        .sout     (sout),
        .rx_word  (rx_data)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && edge_last) state_d = ST_TRAIL;
            ST_TRAIL: if (tick) state_d = take ? ST_SHIFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (!enable) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // edge counter, clock phase, receive strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            ph_q   <= 1'b0;
            rxv_q  <= 1'b0;
        end else begin
            rxv_q <= step && edge_last;
            if (!enable || state_q != ST_SHIFT) begin
                ph_q <= 1'b0;
            end else if (tick) begin
                ph_q <= ~ph_q;
            end
            if (take)
                edge_q <= '0;
            else if (step)
                edge_q <= edge_last ? '0 : edge_q + EW'(1);
        end
    end

    // outputs
    always_comb begin
        cs_n     = (state_q == ST_IDLE);
        sclk     = cpol ^ ph_q;
        mosi     = sout;
        rx_valid = rxv_q;
        busy     = (state_q != ST_IDLE) || tx_valid;
        tx_ready = enable && ((state_q == ST_IDLE) || (state_q == ST_TRAIL && tick));
    end
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cpol,
    input logic tx_valid,
    input logic tx_ready,
    input logic sclk,
    input logic cs_n,
    input logic rx_valid,
    input logic busy
);
    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == cpol));

    // R12
    start_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !cs_n);

    // R10
    disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cs_n);

    // R3
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11
    busy_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // R7
    lead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $stable(sclk));
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cpol     (cpol),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .rx_valid (rx_valid),
    .busy     (busy)
);

// File: tb/spi_frame_master_bench.sv
`timescale 1ns/1ps
module spi_frame_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        loopback = 1'b0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [3:0]  dsize = 4'd7;
    logic [7:0]  prescale = 8'd2;
    logic [7:0]  rate = 8'd0;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        miso = 1'b0;
    logic        sclk;
    logic        mosi;
    logic        cs_n;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        busy;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] tw [0:3];
    logic [15:0] sw [0:3];

    always #4 clk = ~clk;

    spi_frame_master u_spi_frame_master (
        .clk(clk), .rst_n(rst_n), .enable(enable), .loopback(loopback),
        .cpol(cpol), .cpha(cpha), .dsize(dsize), .prescale(prescale),
        .rate(rate), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy)
    );

    function automatic int half_of(input logic [7:0] p, input logic [7:0] r);
        int pe = int'(p) & 32'hFE;
        if (pe == 0) pe = 2;
        return (pe / 2) * (int'(r) + 1);
    endfunction

    function automatic logic [15:0] mask_of(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Far-end device model plus handshake driver for a burst of cnt words.
    task automatic run_burst(input int cnt);
        int n = int'(dsize) + 1;
        int hp = half_of(prescale, rate);
        int fidx = 0, ridx = 0, k = 0, since = 0, aidx = 0, cyc = 0, b = 0;
        int gap;
        int rising = 0;
        logic [15:0] acc = '0;
        bit pend, done = 0, busy_ok = 1;
        logic pcs, psck;
        @(negedge clk);
        tx_data = tw[0];
        tx_valid = 1'b1;
        pend = tx_valid && tx_ready;
        pcs = cs_n;
        psck = sclk;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            since++;
            if (pend) begin
                aidx++;
                if (aidx < cnt) tx_data = tw[aidx];
                else tx_valid = 1'b0;
            end
            pend = tx_valid && tx_ready;
            if (!cs_n && !busy) busy_ok = 0;
            if (pcs && !cs_n) begin
                rising++;
                since = 0;
                b = n - 1;
                miso = loopback ? ~sw[fidx][b] : sw[fidx][b];
            end
            if (sclk !== psck) begin
                gap = (k == 0 && fidx > 0) ? 2 * hp : hp;
                // R6 R7 R8: spacing of lead, half-periods and chain gap
                check(since == gap, "R6/R7/R8 transition spacing", since, gap);
                since = 0;
                if ((k % 2) == int'(cpha)) begin
                    acc = {acc[14:0], mosi};
                    b--;
                    if (b >= 0) miso = loopback ? ~sw[fidx][b] : sw[fidx][b];
                end
                k++;
                if (k == 2 * n) begin
                    // R1 R2 R5: sent word as seen by the far end
                    check(acc == (tw[fidx] & mask_of(n)), "R1/R2/R5 sent word",
                          acc, tw[fidx] & mask_of(n));
                    fidx++;
                    k = 0;
                    acc = '0;
                    b = n - 1;
                    if (fidx < cnt) miso = loopback ? ~sw[fidx][b] : sw[fidx][b];
                end
            end
            if (rx_valid) begin
                if (ridx < cnt)
                    check(rx_data == (sw[ridx] & mask_of(n)), "R3/R5/R9 received word",
                          rx_data, sw[ridx] & mask_of(n));
                ridx++;
            end
            if (!pcs && cs_n) begin
                check(since == hp, "R7 select release", since, hp);
                check(fidx == cnt && rising == 1, "R8 select held across burst",
                      fidx, cnt);
                done = 1;
            end
            pcs = cs_n;
            psck = sclk;
        end
        check(done, "R1 frame completes (timeout)", done, 1);
        check(ridx == cnt, "R3 one strobe per frame", ridx, cnt);
        check(busy_ok, "R11 busy during frame", busy_ok, 1);
        @(negedge clk);
        check(sclk == cpol && cs_n == 1'b1, "R4 idle clock level", {cs_n, sclk}, {1'b1, cpol});
        check(busy == 1'b0, "R11 busy low when idle", busy, 0);
    endtask

    task automatic set_cfg(input logic pl, input logic ph, input logic [3:0] ds,
                           input logic [7:0] ps, input logic [7:0] rt, input logic lb);
        @(negedge clk);
        cpol = pl; cpha = ph; dsize = ds; prescale = ps; rate = rt; loopback = lb;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E3D);
        repeat (3) @(negedge clk);
        // reset state
        check(cs_n == 1 && sclk == 0 && rx_valid == 0 && busy == 0 && tx_ready == 0,
              "R4/R10 reset state", {cs_n, sclk, rx_valid, busy, tx_ready}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b1, "R12 ready when idle", tx_ready, 1);

        // directed: 8-bit, mode 0
        tw[0] = 16'h12A5; sw[0] = 16'h003C;
        set_cfg(0, 0, 4'd7, 8'd2, 8'd0, 0);
        run_burst(1);
        // shortest frame, mode 3, prescale 0 treated as 2
        tw[0] = 16'hFFF9; sw[0] = 16'h0006;
        set_cfg(1, 1, 4'd3, 8'd0, 8'd0, 0);
        run_burst(1);
        // full 16-bit, odd prescale rounds down, rate 1
        tw[0] = 16'h8001; sw[0] = 16'hC3A5;
        set_cfg(0, 1, 4'd15, 8'd3, 8'd1, 0);
        run_burst(1);
        // largest prescale, short frame
        tw[0] = 16'h000A; sw[0] = 16'h0005;
        set_cfg(1, 0, 4'd3, 8'd255, 8'd0, 0);
        run_burst(1);
        // R8 chained burst of three
        tw[0] = 16'h0AB; tw[1] = 16'h154; tw[2] = 16'h1FF;
        sw[0] = 16'h1C7; sw[1] = 16'h038; sw[2] = 16'h000;
        set_cfg(1, 0, 4'd8, 8'd4, 8'd1, 0);
        run_burst(3);
        // R9 loopback, pin driven inverted
        tw[0] = 16'hBEEF; sw[0] = 16'hBEEF;
        set_cfg(0, 1, 4'd11, 8'd2, 8'd2, 1);
        run_burst(1);

        // R10 disabled: nothing starts
        begin
            bit quiet = 1;
            set_cfg(1, 0, 4'd7, 8'd6, 8'd1, 0);
            enable = 1'b0;
            tx_data = 16'h5A; tx_valid = 1'b1;
            repeat (40) begin
                @(negedge clk);
                if (!(cs_n == 1 && sclk == 1 && tx_ready == 0)) quiet = 0;
            end
            check(quiet, "R10 disabled holds idle", quiet, 1);
            check(busy == 1'b1, "R11 busy with pending word", busy, 1);
            // R10 abort mid-frame
            enable = 1'b1;
            @(negedge clk);
            tx_valid = 1'b0;
            repeat (10) @(negedge clk);
            check(cs_n == 1'b0, "R12 frame started after enable", cs_n, 0);
            enable = 1'b0;
            @(negedge clk);
            check(cs_n == 1'b1 && sclk == 1'b1, "R10 abort restores idle",
                  {cs_n, sclk}, 2'b11);
            enable = 1'b1;
            @(negedge clk);
        end

        // constrained random
        for (int i = 0; i < 40; i++) begin
            int cnt = 1 + int'($urandom_range(1, 0));
            for (int j = 0; j < 4; j++) begin
                tw[j] = 16'($urandom);
                sw[j] = 16'($urandom);
            end
            set_cfg(1'($urandom), 1'($urandom), 4'($urandom_range(15, 3)),
                    8'(2 * $urandom_range(3, 0)), 8'($urandom_range(3, 0)),
                    1'($urandom_range(4, 0) == 0));
            if (loopback)
                for (int j = 0; j < 4; j++) sw[j] = tw[j];
            run_burst(cnt);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule